// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block turns a bank of already-synchronized GPIO input levels into interrupt status. Each pin is configured independently: level or edge sensitivity, active-high/rising or active-low/falling polarity, an extra dual-edge option, an enable, a mask and an optional debounce filter clocked by a slow tick. The configuration vectors come straight from a register file that sits outside this block, and the end-of-interrupt vector arrives as a one-cycle write strobe carrying write-one-to-clear data.

Edge events are latched until software clears them. Level conditions are not latched and simply follow the filtered input. Two status vectors come out. Raw status shows every enabled pin's condition whether it is masked or not. Masked status gates raw status with the enable and the mask. A registered interrupt line is the OR of the masked status.

Top module: `gpio_irq_detect`

## Requirements
- R1: After the asynchronous reset, raw status, masked status and the interrupt line are all zero.
- R2: For an enabled pin whose type bit is 0 (level), the raw status bit equals 1 when the filtered input equals the polarity bit, one clock after the input is sampled; the end-of-interrupt vector does not clear it.
- R3: For an enabled pin whose type bit is 1 (edge) and whose dual-edge bit is 0, a polarity bit of 1 latches status on a 0-to-1 transition and a polarity bit of 0 latches it on a 1-to-0 transition; the other transition does not set it, and a latched bit stays set after the input returns.
- R4: For an enabled edge-type pin with its dual-edge bit at 1, both transitions latch status, whatever the polarity bit holds.
- R5: A 1 in bit n of the end-of-interrupt vector clears pin n's latched edge status at that clock; a 0 bit leaves status unchanged.
- R6: When an edge event and an end-of-interrupt clear for the same pin fall on the same clock, the status bit ends up set.
- R7: Masked status equals raw status AND enable AND NOT mask; a masked pin still shows in raw status.
- R8: A pin whose enable is 0 shows 0 in raw status one clock later, and transitions while it is disabled latch nothing.
- R9: With debounce enabled on a pin, a new input level reaches detection only after it has differed from the accepted level on DB_TICKS consecutive tick cycles (default 4); any return to the accepted level restarts the count. With debounce disabled the input passes through unfiltered.
- R10: The interrupt output is registered: it is 1 exactly one clock after any masked status bit is 1, and 0 one clock after none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| tick_i | input | 1 | Slow-clock tick that paces debounce counting |
| irq_en_i | input | NUM_PINS | Per-pin interrupt enable |
| irq_mask_i | input | NUM_PINS | Per-pin mask, 1 hides the pin from the interrupt line |
| trig_edge_i | input | NUM_PINS | Type: 1 edge, 0 level |
| trig_pol_i | input | NUM_PINS | Polarity: 1 rising/high, 0 falling/low |
| trig_dual_i | input | NUM_PINS | Dual-edge select for edge-type pins |
| db_en_i | input | NUM_PINS | Per-pin debounce enable |
| eoi_i | input | NUM_PINS | End-of-interrupt strobe, write-one-to-clear per pin |
| raw_status_o | output | NUM_PINS | Raw status of enabled pins |
| int_status_o | output | NUM_PINS | Masked status |
| irq_o | output | 1 | Registered OR of masked status |

## Verification
Raw status lands one clock after the input is sampled, the interrupt line one clock after that, and masked status follows the mask combinationally from the raw register; with debounce on, detection is delayed by exactly the DB_TICKS-th tick plus one clock. Inputs are driven on the falling edge and every output is read on the following falling edge, so each check looks at the state after exactly the registers its result passes through. Directed sequences pin down single-cycle cases such as the end-of-interrupt collision and the debounce threshold, and a seeded random phase compares all three outputs every cycle with a bench model stepped on the same edges.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  typedef struct packed {
    logic en;
    logic edge_sel;
    logic pol;
    logic dual;
    logic db;
  } pin_cfg_t;

  function automatic logic edge_hit(input pin_cfg_t cfg, input logic rise, input logic fall);
    if (cfg.dual) return rise | fall;
    return cfg.pol ? rise : fall;
  endfunction

endpackage

// File: rtl/gid_debounce.sv
`timescale 1ns/1ps
module gid_debounce #(
  parameter int DB_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  input  logic db_en_i,
  output logic level_o
);
  localparam int CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

  logic          filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!db_en_i) begin
      filt_q <= pin_i;
      cnt_q  <= '0;
    end else if (pin_i == filt_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        filt_q <= pin_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = db_en_i ? filt_q : pin_i;

  // R9: without a tick the accepted level cannot move
  a_r9_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_en_i && !tick_i) |=> $stable(filt_q));

  // R9: a matching input never changes the accepted level
  a_r9_hold_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_en_i && pin_i == filt_q) |=> $stable(filt_q));

endmodule

// File: rtl/gid_pin_detect.sv
`timescale 1ns/1ps
module gid_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     level_i,
  input  pin_cfg_t cfg_i,
  input  logic     eoi_i,
  output logic     stat_o
);
  logic prev_q, stat_q;
  logic rise, fall, evt;

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;
  assign evt  = cfg_i.en & cfg_i.edge_sel & edge_hit(cfg_i, rise, fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                stat_q <= 1'b0;
    else if (!cfg_i.en)         stat_q <= 1'b0;
    else if (!cfg_i.edge_sel)   stat_q <= (level_i == cfg_i.pol);
    else if (evt)               stat_q <= 1'b1;  // new edge beats clear
    else if (eoi_i)             stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

  a_r8_disabled_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> !stat_q);

  a_r2_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !cfg_i.edge_sel) |=> (stat_q == $past(level_i == cfg_i.pol)));

  a_r6_edge_beats_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && cfg_i.edge_sel && eoi_i && (rise || fall) && cfg_i.dual) |=> stat_q);

  a_r5_eoi_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && cfg_i.edge_sel && eoi_i && !rise && !fall) |=> !stat_q);

  a_r3_latched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && cfg_i.edge_sel && stat_q && !eoi_i) |=> stat_q);

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DB_TICKS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                tick_i,
  input  logic [NUM_PINS-1:0] irq_en_i,
  input  logic [NUM_PINS-1:0] irq_mask_i,
  input  logic [NUM_PINS-1:0] trig_edge_i,
  input  logic [NUM_PINS-1:0] trig_pol_i,
  input  logic [NUM_PINS-1:0] trig_dual_i,
  input  logic [NUM_PINS-1:0] db_en_i,
  input  logic [NUM_PINS-1:0] eoi_i,
  output logic [NUM_PINS-1:0] raw_status_o,
  output logic [NUM_PINS-1:0] int_status_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] level;
  logic [NUM_PINS-1:0] stat;
  logic                irq_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{en: irq_en_i[p], edge_sel: trig_edge_i[p], pol: trig_pol_i[p],
                   dual: trig_dual_i[p], db: db_en_i[p]};

    gid_debounce #(.DB_TICKS(DB_TICKS)) u_db (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pin_i[p]),
      .tick_i  (tick_i),
      .db_en_i (cfg.db),
      .level_o (level[p])
    );

    gid_pin_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (level[p]),
      .cfg_i   (cfg),
      .eoi_i   (eoi_i[p]),
      .stat_o  (stat[p])
    );
  end

  assign raw_status_o = stat;
  assign int_status_o = stat & irq_en_i & ~irq_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |int_status_o;
  end

  assign irq_o = irq_q;

  a_r10_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(raw_status_o & irq_en_i & ~irq_mask_i)) |=> irq_o);

  a_r10_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(raw_status_o & irq_en_i & ~irq_mask_i)) |=> !irq_o);

  a_r8_disabled_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |=> (raw_status_o == '0));

endmodule

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;
  localparam int N  = 32;
  localparam int DB = 4;
  localparam int P  = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin, en, mask, edge_s, pol, dual, db, eoi;
  logic         tick;
  logic [N-1:0] raw, ints;
  logic         irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N), .DB_TICKS(DB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tick_i(tick),
    .irq_en_i(en), .irq_mask_i(mask), .trig_edge_i(edge_s), .trig_pol_i(pol),
    .trig_dual_i(dual), .db_en_i(db), .eoi_i(eoi),
    .raw_status_o(raw), .int_status_o(ints), .irq_o(irq)
  );

  // reference model state
  logic [N-1:0] m_filt, m_prev, m_stat;
  int           m_cnt [N];
  logic         m_irq;

  function automatic logic hit_of(logic d, logic p, logic r, logic f);
    return d ? (r | f) : (p ? r : f);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_filt = '0; m_prev = '0; m_stat = '0; m_irq = 1'b0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
    end else begin
      logic [N-1:0] eff;
      m_irq = |(m_stat & en & ~mask);
      for (int i = 0; i < N; i++) begin
        logic r, f;
        eff[i] = db[i] ? m_filt[i] : pin[i];
        r = eff[i] & ~m_prev[i];
        f = ~eff[i] & m_prev[i];
        if (!en[i])                                 m_stat[i] = 1'b0;
        else if (!edge_s[i])                        m_stat[i] = (eff[i] == pol[i]);
        else if (hit_of(dual[i], pol[i], r, f))     m_stat[i] = 1'b1;
        else if (eoi[i])                            m_stat[i] = 1'b0;
        m_prev[i] = eff[i];
        if (!db[i]) begin
          m_filt[i] = pin[i]; m_cnt[i] = 0;
        end else if (pin[i] == m_filt[i]) begin
          m_cnt[i] = 0;
        end else if (tick) begin
          if (m_cnt[i] == DB - 1) begin m_filt[i] = pin[i]; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stepn(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pin = '0; en = '0; mask = '0; edge_s = '0; pol = '0;
    dual = '0; db = '0; eoi = '0; tick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 raw after reset", raw, '0);
    chk("R1 masked after reset", ints, '0);
    chk("R1 irq after reset", {31'd0, irq}, '0);

    // level, active high
    en[P] = 1'b1; pol[P] = 1'b1;
    step();
    chk("R2 level low input", raw, '0);
    pin[P] = 1'b1;
    step();
    chk("R2 level high input", raw, 32'h1 << P);
    step();
    chk("R10 irq one clock later", {31'd0, irq}, 32'd1);
    eoi[P] = 1'b1;
    step();
    eoi = '0;
    chk("R2 level ignores eoi", raw, 32'h1 << P);
    pin[P] = 1'b0;
    step();
    chk("R2 level drops", raw, '0);
    step();
    chk("R10 irq drops", {31'd0, irq}, '0);

    // rising edge
    edge_s[P] = 1'b1;
    step();
    pin[P] = 1'b1;
    step();
    chk("R3 rising latched", raw, 32'h1 << P);
    pin[P] = 1'b0;
    step();
    chk("R3 latched after return", raw, 32'h1 << P);
    eoi = ~(32'h1 << P);
    step();
    eoi = '0;
    chk("R5 zero eoi bit no effect", raw, 32'h1 << P);
    eoi[P] = 1'b1;
    step();
    eoi = '0;
    chk("R5 eoi clears", raw, '0);

    // falling edge
    pol[P] = 1'b0;
    pin[P] = 1'b1;
    step();
    chk("R3 rise ignored in falling mode", raw, '0);
    pin[P] = 1'b0;
    step();
    chk("R3 falling latched", raw, 32'h1 << P);

    // collision: bit already set, another falling edge meets eoi
    pin[P] = 1'b1;
    step();
    pin[P] = 1'b0; eoi[P] = 1'b1;
    step();
    eoi = '0;
    chk("R6 edge beats eoi", raw, 32'h1 << P);
    eoi[P] = 1'b1;
    step();
    eoi = '0;

    // dual edge, polarity high
    dual[P] = 1'b1; pol[P] = 1'b1;
    pin[P] = 1'b1;
    step();
    chk("R4 dual rising", raw, 32'h1 << P);
    eoi[P] = 1'b1;
    step();
    eoi = '0;
    pin[P] = 1'b0;
    step();
    chk("R4 dual falling despite polarity", raw, 32'h1 << P);
    eoi[P] = 1'b1;
    step();
    eoi = '0;

    // mask
    mask[P] = 1'b1;
    pin[P] = 1'b1;
    step();
    chk("R7 raw shows masked pin", raw, 32'h1 << P);
    chk("R7 masked status hidden", ints, '0);
    step();
    chk("R7 irq stays low when masked", {31'd0, irq}, '0);
    mask[P] = 1'b0;
    step();
    chk("R7 unmasked status", ints, 32'h1 << P);
    eoi[P] = 1'b1;
    step();
    eoi = '0;

    // disable
    en[P] = 1'b0;
    pin[P] = 1'b0;
    step();
    chk("R8 disabled raw", raw, '0);
    pin[P] = 1'b1;
    step();
    pin[P] = 1'b0;
    step();
    chk("R8 edges ignored while disabled", raw, '0);
    en[P] = 1'b1;
    step();
    chk("R8 nothing latched on re-enable", raw, '0);

    // debounce, level active high
    edge_s[P] = 1'b0; dual[P] = 1'b0; pol[P] = 1'b1; db[P] = 1'b1;
    stepn(2);
    pin[P] = 1'b1; tick = 1'b1;
    stepn(DB - 1);
    tick = 1'b0;
    stepn(2);
    chk("R9 not accepted before last tick", raw, '0);
    tick = 1'b1;
    step();
    tick = 1'b0;
    step();
    chk("R9 accepted after last tick", raw, 32'h1 << P);
    pin[P] = 1'b0; tick = 1'b1;
    stepn(2);
    pin[P] = 1'b1;
    stepn(DB);
    tick = 1'b0;
    step();
    chk("R9 glitch restarts count", raw, 32'h1 << P);
    db[P] = 1'b0; pin[P] = 1'b0;
    step();
    chk("R9 bypass passes input", raw, '0);

    // random phase against model
    for (int c = 0; c < 6000; c++) begin
      if (c % 50 == 0) begin
        en = $urandom; mask = $urandom; edge_s = $urandom; pol = $urandom;
        dual = $urandom; db = $urandom;
      end
      pin  = pin ^ ($urandom & $urandom);
      tick = ($urandom % 3) == 0;
      eoi  = (($urandom % 4) == 0) ? $urandom : '0;
      step();
      chk("R2 R3 R4 R5 R6 R8 R9 random raw", raw, m_stat);
      chk("R7 random masked", ints, m_stat & en & ~mask);
      chk("R10 random irq", {31'd0, irq}, {31'd0, m_irq});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule